// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one machine cycle at a time on an 8-bit bus where the low address byte and the data share the same pins. A requester gives a cycle kind, a 16-bit address and a write byte. The block then steps through T-states, one per clock. In T1 it drives the address and pulses the latch enable. In T2 and T3 it moves the shared pins to data and asserts the read or write strobe, which is active low. An opcode fetch also has a fourth, internal T-state in which no strobe is active.

The block drives the upper address byte, the shared low-address/data lines with their output enable, the address latch enable, the read and write strobes, the memory/IO select and two status bits. It captures the byte returned by a read and gives a one-cycle completion pulse. A new request is taken only while the sequencer is idle, so a processor core can issue cycles back to back: the next request is offered on the cycle after completion.

Top module: `busCycleSeq`

## Requirements
- R1: After reset, and whenever no cycle is in progress, rdN and wrN are high, ale is low, adOe is low, done is low, reqReady is high, s1/s0 are 00 and ioM is low.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both high and reqKind is a defined code: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. Codes 5 to 7 are ignored, and the block stays idle with every output at its R1 value.
- R3: An opcode fetch lasts 4 T-states. Every other kind lasts 3. done is high for exactly the last T-state, and reqReady goes high again on the following cycle.
- R4: In T1, ale is high, addrHi equals address bits 15:8, adOut equals address bits 7:0, and adOe is high.
- R5: {s1,s0} is 11 for a fetch, 10 for a memory or I/O read, and 01 for a memory or I/O write. It holds that value from T1 through the last T-state.
- R6: ioM is high for the two I/O kinds and low for the three memory kinds, and it is held for the whole cycle.
- R7: For fetch and read kinds, rdN is low in T2 and T3 and high in T1 and T4, and adOe is low in T2 and T3.
- R8: For write kinds, wrN is low in T2 and T3, adOut carries the write byte and adOe stays high.
- R9: rdData takes the value on adIn at the clock edge that ends T3 of a fetch or read. From the next cycle it holds that value until the next fetch or read. Write cycles and ignored requests leave rdData unchanged.
- R10: rdN and wrN are never low together, and ale is never high while either strobe is low.
- R11: addrHi holds the request's upper address byte for every T-state of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqKind | input | 3 | Cycle kind code (see R2) |
| reqAddr | input | 16 | Cycle address |
| reqWdata | input | 8 | Byte for write kinds |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| addrHi | output | 8 | Upper address byte |
| adOut | output | 8 | Shared low-address/data, outgoing value |
| adOe | output | 1 | Output enable for adOut |
| adIn | input | 8 | Shared low-address/data, incoming value |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ioM | output | 1 | High for I/O cycles, low for memory cycles |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rdData | output | 8 | Byte captured by the last fetch or read |
| done | output | 1 | One-cycle pulse in the last T-state |

## Verification
The bench sweeps all eight kind codes over a set of address and data patterns. It checks each port against values computed from the kind and the T-state number, and it starts each cycle immediately after the previous done, so back-to-back handling is exercised. A sequencer that mishandled the fetch length would place done in T3, or start the next cycle one state early. A design that left adOe high during read T2/T3 would fight the external driver. Undefined codes 5 to 7 are offered to check that they start nothing and leave rdData alone, which catches a decoder that treats them as reads. The bench changes adIn in T2 and again right after the capture edge to confirm that rdData takes the byte present at the end of T3 and not the byte from a cycle earlier or later.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    KIND_FETCH  = 3'd0,
    KIND_MEM_RD = 3'd1,
    KIND_MEM_WR = 3'd2,
    KIND_IO_RD  = 3'd3,
    KIND_IO_WR  = 3'd4
  } cycleKind_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } tState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic latchReq;     // capture address and write byte
    logic latchRd;      // capture incoming byte at this edge
    logic cycleActive;  // some T-state in progress
    logic driveAddr;    // low address byte on shared lines
    logic driveData;    // write byte on shared lines
  } seqStrobe_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  output logic       reqReady,
  output logic       ale,
  output logic       rdN,
  output logic       wrN,
  output logic       ioM,
  output logic       s1,
  output logic       s0,
  output logic       done,
  output seqStrobe_t strb
);

  tState_t    state, stateNext;
  cycleKind_t kindQ;
  logic       kindOk, isFetch, isRead, isWrite, isIo, busy, dataPhase;

  assign kindOk = (reqKind <= 3'd4);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kindQ <= KIND_FETCH;
    end else begin
      state <= stateNext;
      if (strb.latchReq) kindQ <= cycleKind_t'(reqKind);
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strb.latchReq) stateNext = ST_T1;
      ST_T1:   stateNext = ST_T2;
      ST_T2:   stateNext = ST_T3;
      ST_T3:   stateNext = isFetch ? ST_T4 : ST_IDLE;
      ST_T4:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign isFetch   = (kindQ == KIND_FETCH);
  assign isRead    = isFetch || (kindQ == KIND_MEM_RD) || (kindQ == KIND_IO_RD);
  assign isWrite   = (kindQ == KIND_MEM_WR) || (kindQ == KIND_IO_WR);
  assign isIo      = (kindQ == KIND_IO_RD) || (kindQ == KIND_IO_WR);
  assign busy      = (state != ST_IDLE);
  assign dataPhase = (state == ST_T2) || (state == ST_T3);

  assign reqReady = !busy;
  assign ale      = (state == ST_T1);
  assign rdN      = !(isRead && dataPhase);
  assign wrN      = !(isWrite && dataPhase);
  assign ioM      = busy && isIo;
  assign s1       = busy && isRead;
  assign s0       = busy && (isFetch || isWrite);
  assign done     = ((state == ST_T3) && !isFetch) || (state == ST_T4);

  assign strb.latchReq    = reqReady && reqValid && kindOk;
  assign strb.latchRd     = (state == ST_T3) && isRead;
  assign strb.cycleActive = busy;
  assign strb.driveAddr   = (state == ST_T1);
  assign strb.driveData   = isWrite && dataPhase;

  // R10
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  // R10
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN));
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);
  // R7
  rd_after_ale_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> $past(ale));
  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && !$past(reqReady)) |-> $stable({s1, s0, ioM}));

endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strb,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        adIn,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [DATA_W-1:0]        rdData
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdData <= '0;
    end else begin
      if (strb.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.latchRd) rdData <= adIn;
    end
  end

  assign addrHi = strb.cycleActive ? addrQ[ADDR_W-1 -: HI_W] : '0;
  assign adOe   = strb.driveAddr || strb.driveData;
  assign adOut  = strb.driveAddr ? addrQ[DATA_W-1:0]
                : (strb.driveData ? wdataQ : '0);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cycleActive && $past(strb.cycleActive)) |-> $stable(addrHi));
  // R9
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.latchRd) |-> $stable(rdData));

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [2:0]               reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     reqReady,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     ioM,
  output logic                     s1,
  output logic                     s0,
  output logic [DATA_W-1:0]        rdData,
  output logic                     done
);

  seqStrobe_t strb;

  busSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqReady(reqReady), .ale(ale), .rdN(rdN), .wrN(wrN), .ioM(ioM),
    .s1(s1), .s0(s0), .done(done), .strb(strb)
  );

  busSeqDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .adIn(adIn), .addrHi(addrHi), .adOut(adOut),
    .adOe(adOe), .rdData(rdData)
  );

  // R4
  ale_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);

endmodule

// File: tb/sim_busCycleSeq.sv
`timescale 1ns/1ps
module sim_busCycleSeq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqKind = 3'd0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic [7:0] adIn = '0;
  logic       reqReady, adOe, ale, rdN, wrN, ioM, s1, s0, done;
  logic [7:0] addrHi, adOut, rdData;

  int vecCount = 0;
  int errCount = 0;
  int cycleCnt = 0;
  logic [7:0] lastRd = 8'h00;

  always #2.5 clk = ~clk;

  busCycleSeq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .addrHi(addrHi), .adOut(adOut), .adOe(adOe), .adIn(adIn), .ale(ale),
    .rdN(rdN), .wrN(wrN), .ioM(ioM), .s1(s1), .s0(s0), .rdData(rdData),
    .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 100000) begin
      errCount++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycleCnt);
      finish_run();
    end
  end

  task automatic check_idle(input string tag);
    chk({tag, " R1 rdN"}, {31'd0, rdN}, 32'd1);
    chk({tag, " R1 wrN"}, {31'd0, wrN}, 32'd1);
    chk({tag, " R1 ale"}, {31'd0, ale}, 32'd0);
    chk({tag, " R1 adOe"}, {31'd0, adOe}, 32'd0);
    chk({tag, " R1 done"}, {31'd0, done}, 32'd0);
    chk({tag, " R1 reqReady"}, {31'd0, reqReady}, 32'd1);
    chk({tag, " R1 status"}, {29'd0, s1, s0, ioM}, 32'd0);
  endtask

  // offer one request at a negedge with the sequencer idle
  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] w, input logic [7:0] rv);
    bit isR, isW, valid;
    int len;
    logic [1:0] st;
    valid = (k <= 3'd4);
    isR   = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    isW   = (k == 3'd2) || (k == 3'd4);
    len   = (k == 3'd0) ? 4 : 3;
    st    = (k == 3'd0) ? 2'b11 : (isR ? 2'b10 : 2'b01);
    reqKind = k; reqAddr = a; reqWdata = w; reqValid = 1'b1;
    adIn = ~rv;
    @(negedge clk);
    reqValid = 1'b0;
    if (!valid) begin
      // R2: undefined code starts nothing
      check_idle("R2 ignored");
      chk("R9 rdData kept", {24'd0, rdData}, {24'd0, lastRd});
      return;
    end
    for (int t = 1; t <= len; t++) begin
      if (t == 2) adIn = rv;
      chk("R3 reqReady busy", {31'd0, reqReady}, 32'd0);
      chk("R3 done", {31'd0, done}, {31'd0, (t == len)});
      chk("R4 ale", {31'd0, ale}, {31'd0, (t == 1)});
      chk("R11 addrHi", {24'd0, addrHi}, {24'd0, a[15:8]});
      chk("R5 status", {30'd0, s1, s0}, {30'd0, st});
      chk("R6 ioM", {31'd0, ioM}, {31'd0, (k == 3'd3 || k == 3'd4)});
      chk("R7 rdN", {31'd0, rdN}, {31'd0, !(isR && (t == 2 || t == 3))});
      chk("R8 wrN", {31'd0, wrN}, {31'd0, !(isW && (t == 2 || t == 3))});
      chk("R4 R7 R8 adOe", {31'd0, adOe},
          {31'd0, (t == 1) || (isW && (t == 2 || t == 3))});
      if (t == 1) chk("R4 adOut addr", {24'd0, adOut}, {24'd0, a[7:0]});
      if (isW && (t == 2 || t == 3)) chk("R8 adOut data", {24'd0, adOut}, {24'd0, w});
      if (t == 4) chk("R9 rdData after T3", {24'd0, rdData}, {24'd0, rv});
      @(negedge clk);
      if (t == 3) adIn = ~rv;
    end
    if (isR) lastRd = rv;
    check_idle("R3 after");
    chk("R9 rdData", {24'd0, rdData}, {24'd0, lastRd});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("reset");
    chk("R9 reset rdData", {24'd0, rdData}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check_idle("post reset");
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 8; k++) begin
        logic [15:0] a;
        logic [7:0]  w, rv;
        a  = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF :
             16'((p * 16'h3C5A) ^ (k * 16'h1111));
        w  = 8'((p * 37 + k * 11) ^ 8'hA5);
        rv = 8'((p * 53 + k * 29) ^ 8'h3C);
        run_cycle(3'(k), a, w, rv);
      end
    end
    finish_run();
  end

endmodule